// File: doc/BRIEF.md
# Wakeup and Kickstart Power Controller

This block decides when a system's main supply should be switched on. It watches two wake sources. The first is an alarm comparator: it matches the running day/date, hours, minutes and seconds against programmed alarm values. The second is a push-button style kick input, which reacts to a falling edge. Each source sets a sticky event flag. Each flag has its own interrupt enable. The flags drive an active-low, open-drain interrupt, and an enabled event drives the open-drain power-enable output.

A wake event that arrives while the system is off starts a power-on attempt. If the supply-good input rises before a programmable tick count runs out, the attempt succeeds. The power-down request bit is then cleared by hardware, and power-enable stays driven. If the count runs out first, power-enable is released and the block goes back to waiting. The flag that caused the attempt stays set. Software turns the system off by setting the power-down bit, and that write is only accepted once both flags are clear.

Pad drivers are outside the block. `irq_low` and `pwr_drive` are the pull-low enables of the open-drain pins: a 1 means the pin is pulled low, and a 0 means it is high impedance.

Top module: `wake_power_ctrl`

## Requirements
- R1: The alarm flag (`flags` bit 0) sets in the cycle after day, hour, minute and second all first equal the alarm values. A mismatch in any single field leaves it clear.
- R2: The kick flag (`flags` bit 1) sets on the third rising clock edge after `kick_n` falls. A rising `kick_n` sets nothing.
- R3: `irq_low` is 1 only while supply is good and some flag is set with its `int_en` bit (bit 0 alarm, bit 1 kick) also set. A flag whose enable is 0 does not assert it.
- R4: A one-cycle `flags_rd` clears both flags. A `flags_wr` clears each flag whose `flags_wdata` bit is 0, and leaves each flag whose bit is 1 unchanged.
- R5: An enabled event while off drives `pwr_drive` at once. If `supply_good` rises during the attempt, `pdn_bit` clears to 0 on the next edge and `pwr_drive` stays 1.
- R6: A `pdn_wr` with `pdn_wdata`=1 is ignored while either flag is set. Once both flags are clear it sets `pdn_bit`, and `pwr_drive` drops to 0.
- R7: An attempt without supply lasts exactly `tmo_ticks` cycles (`tmo_ticks` of at least 1). After that, `pwr_drive` returns to 0 and the triggering flag stays set.
- R8: While off and not attempting, `pwr_drive` equals `prs`.
- R9: While powered with `pdn_bit`=1, an enabled wake event clears `pdn_bit` and drives `pwr_drive`. A masked event leaves `pdn_bit` at 1.
- R10: `irq_low` is 0 whenever `supply_good` is 0, even with an enabled flag set.
- R11: Loss of `supply_good` while powered returns the block to the off state on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_day | input | DAY_W | Current day/date |
| cur_hour | input | HOUR_W | Current hours |
| cur_min | input | MIN_W | Current minutes |
| cur_sec | input | SEC_W | Current seconds |
| alm_day | input | DAY_W | Alarm day/date |
| alm_hour | input | HOUR_W | Alarm hours |
| alm_min | input | MIN_W | Alarm minutes |
| alm_sec | input | SEC_W | Alarm seconds |
| kick_n | input | 1 | Asynchronous kick input, active on falling edge |
| supply_good | input | 1 | Primary supply above the fail threshold |
| tmo_ticks | input | TMO_W | Power-on attempt length in cycles |
| int_en | input | 2 | Interrupt/wake enables: bit 0 alarm, bit 1 kick |
| prs | input | 1 | Keep power-enable driven while off |
| flags_rd | input | 1 | Flag register read strobe (clears both flags) |
| flags_wr | input | 1 | Flag register write strobe |
| flags_wdata | input | 2 | Flag write data; a 0 bit clears that flag |
| pdn_wr | input | 1 | Power-down bit write strobe |
| pdn_wdata | input | 1 | Power-down bit write value |
| flags | output | 2 | Event flags: bit 0 alarm, bit 1 kick |
| pdn_bit | output | 1 | Power-down request bit |
| irq_low | output | 1 | Interrupt pin pull-low enable |
| pwr_drive | output | 1 | Power-enable pin pull-low enable |

## Verification
The power sequencing is exercised through four wake patterns:
- A kick with no supply, which shows the exact length of the timeout window and that the flag is kept afterwards.
- An alarm match followed by supply arrival, which shows the automatic clearing of the power-down bit.
- A masked kick while powered, which shows that the enable gates both interrupt and wake.
- An enabled kick while powered after a software power-down, which shows the power-enable is driven again without a power cycle.

Alarm matching is tried with a single-field mismatch before the full match, so a comparator that ignores one field is caught. Power-down writes are tried both with a flag pending and with both flags clear, which tells the guard apart from an unconditional write.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    PS_OFF     = 2'd0,
    PS_ATTEMPT = 2'd1,
    PS_ON      = 2'd2
  } pwr_state_e;

  localparam int NUM_SRC = 2;
  localparam int SRC_ALARM = 0;
  localparam int SRC_KICK  = 1;
endpackage

// File: rtl/wpc_event_detect.sv
module wpc_event_detect #(
  parameter int DAY_W  = 6,
  parameter int HOUR_W = 5,
  parameter int MIN_W  = 6,
  parameter int SEC_W  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DAY_W-1:0]  cur_day,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic [DAY_W-1:0]  alm_day,
  input  logic [HOUR_W-1:0] alm_hour,
  input  logic [MIN_W-1:0]  alm_min,
  input  logic [SEC_W-1:0]  alm_sec,
  input  logic              kick_n,
  output logic              alarm_hit,
  output logic              kick_hit
);
  logic                   match;
  logic                   match_q;
  logic [SYNC_STAGES-1:0] kick_sync_q;
  logic [SYNC_STAGES-1:0] kick_sync_d;
  logic                   kick_prev_q;

  always_comb begin
    match = (cur_day == alm_day) && (cur_hour == alm_hour) &&
            (cur_min == alm_min) && (cur_sec == alm_sec);
    kick_sync_d = {kick_sync_q[SYNC_STAGES-2:0], kick_n};
    alarm_hit = match && !match_q;
    kick_hit  = kick_prev_q && !kick_sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q     <= 1'b0;
      kick_sync_q <= '1;
      kick_prev_q <= 1'b1;
    end else begin
      match_q     <= match;
      kick_sync_q <= kick_sync_d;
      kick_prev_q <= kick_sync_q[SYNC_STAGES-1];
    end
  end
endmodule

// File: rtl/wpc_flags.sv
module wpc_flags
  import wpc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_hit,
  input  logic [NUM_SRC-1:0] int_en,
  input  logic               flags_rd,
  input  logic               flags_wr,
  input  logic [NUM_SRC-1:0] flags_wdata,
  input  logic               supply_good,
  output logic [NUM_SRC-1:0] flags,
  output logic               irq_low,
  output logic               wake_ev
);
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] flag_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    logic clr;
    always_comb begin
      clr       = flags_rd || (flags_wr && !flags_wdata[i]);
      flag_d[i] = (flag_q[i] && !clr) || src_hit[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  always_comb begin
    flags   = flag_q;
    irq_low = supply_good && |(flag_q & int_en);
    wake_ev = |(src_hit & int_en);
  end
endmodule

// File: rtl/wpc_power_fsm.sv
module wpc_power_fsm
  import wpc_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake_ev,
  input  logic             supply_good,
  input  logic             flags_any,
  input  logic             pdn_wr,
  input  logic             pdn_wdata,
  input  logic             prs,
  input  logic [TMO_W-1:0] tmo_ticks,
  output logic             pdn_bit,
  output logic             pwr_drive,
  output pwr_state_e       state
);
  pwr_state_e       state_q, state_d;
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             pdn_q, pdn_d;
  logic             tmo_done;

  always_comb begin
    state_d  = state_q;
    pdn_d    = pdn_q;
    cnt_en   = 1'b0;
    cnt_d    = cnt_q + 1'b1;
    tmo_done = (cnt_q == tmo_ticks - 1'b1);
    if (pdn_wr && (!pdn_wdata || !flags_any)) pdn_d = pdn_wdata;
    unique case (state_q)
      PS_OFF: begin
        cnt_en = 1'b1;
        cnt_d  = '0;
        if (wake_ev)          state_d = PS_ATTEMPT;
        else if (supply_good) state_d = PS_ON;
      end
      PS_ATTEMPT: begin
        cnt_en = 1'b1;
        if (supply_good) begin
          state_d = PS_ON;
          pdn_d   = 1'b0;
        end else if (tmo_done) begin
          state_d = PS_OFF;
        end
      end
      PS_ON: begin
        if (!supply_good) state_d = PS_OFF;
        else if (wake_ev) pdn_d = 1'b0;
      end
      default: state_d = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_OFF;
      pdn_q   <= 1'b1;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      pdn_q   <= pdn_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  always_comb begin
    state   = state_q;
    pdn_bit = pdn_q;
    unique case (state_q)
      PS_ATTEMPT: pwr_drive = 1'b1;
      PS_ON:      pwr_drive = !pdn_q;
      default:    pwr_drive = prs;
    endcase
  end
endmodule

// File: rtl/wake_power_ctrl.sv
module wake_power_ctrl
  import wpc_pkg::*;
#(
  parameter int DAY_W  = 6,
  parameter int HOUR_W = 5,
  parameter int MIN_W  = 6,
  parameter int SEC_W  = 6,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DAY_W-1:0]  cur_day,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic [DAY_W-1:0]  alm_day,
  input  logic [HOUR_W-1:0] alm_hour,
  input  logic [MIN_W-1:0]  alm_min,
  input  logic [SEC_W-1:0]  alm_sec,
  input  logic              kick_n,
  input  logic              supply_good,
  input  logic [TMO_W-1:0]  tmo_ticks,
  input  logic [1:0]        int_en,
  input  logic              prs,
  input  logic              flags_rd,
  input  logic              flags_wr,
  input  logic [1:0]        flags_wdata,
  input  logic              pdn_wr,
  input  logic              pdn_wdata,
  output logic [1:0]        flags,
  output logic              pdn_bit,
  output logic              irq_low,
  output logic              pwr_drive
);
  logic               alarm_hit, kick_hit, wake_ev;
  logic [NUM_SRC-1:0] src_hit;
  pwr_state_e         state_q;

  assign src_hit[SRC_ALARM] = alarm_hit;
  assign src_hit[SRC_KICK]  = kick_hit;

  wpc_event_detect #(
    .DAY_W(DAY_W), .HOUR_W(HOUR_W), .MIN_W(MIN_W), .SEC_W(SEC_W), .SYNC_STAGES(2)
  ) u_evt (
    .clk(clk), .rst_n(rst_n),
    .cur_day(cur_day), .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
    .alm_day(alm_day), .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec),
    .kick_n(kick_n), .alarm_hit(alarm_hit), .kick_hit(kick_hit)
  );

  wpc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .src_hit(src_hit), .int_en(int_en),
    .flags_rd(flags_rd), .flags_wr(flags_wr), .flags_wdata(flags_wdata),
    .supply_good(supply_good), .flags(flags), .irq_low(irq_low), .wake_ev(wake_ev)
  );

  wpc_power_fsm #(.TMO_W(TMO_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wake_ev(wake_ev), .supply_good(supply_good),
    .flags_any(|flags), .pdn_wr(pdn_wr), .pdn_wdata(pdn_wdata), .prs(prs),
    .tmo_ticks(tmo_ticks), .pdn_bit(pdn_bit), .pwr_drive(pwr_drive), .state(state_q)
  );
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker
  import wpc_pkg::*;
#(
  parameter int DAY_W  = 6,
  parameter int HOUR_W = 5,
  parameter int MIN_W  = 6,
  parameter int SEC_W  = 6,
  parameter int TMO_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DAY_W-1:0]  cur_day,
  input logic [HOUR_W-1:0] cur_hour,
  input logic [MIN_W-1:0]  cur_min,
  input logic [SEC_W-1:0]  cur_sec,
  input logic [DAY_W-1:0]  alm_day,
  input logic [HOUR_W-1:0] alm_hour,
  input logic [MIN_W-1:0]  alm_min,
  input logic [SEC_W-1:0]  alm_sec,
  input logic              supply_good,
  input logic [TMO_W-1:0]  tmo_ticks,
  input logic [1:0]        int_en,
  input logic              prs,
  input logic [1:0]        flags,
  input logic              pdn_bit,
  input logic              irq_low,
  input logic              pwr_drive,
  input pwr_state_e        state
);
  logic             time_eq;
  logic [TMO_W:0]   att_cnt_q;

  assign time_eq = (cur_day == alm_day) && (cur_hour == alm_hour) &&
                   (cur_min == alm_min) && (cur_sec == alm_sec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  att_cnt_q <= '0;
    else if (state == PS_ATTEMPT) att_cnt_q <= att_cnt_q + 1'b1;
    else                         att_cnt_q <= '0;
  end

  assert_alarm_needs_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(time_eq));

  assert_irq_needs_enabled_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & int_en) == 2'b00) |-> !irq_low);

  assert_supply_clears_pdn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_ATTEMPT && supply_good) |=> (!pdn_bit && pwr_drive));

  assert_pdn_set_guarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pdn_bit) |-> ($past(flags) == 2'b00));

  assert_attempt_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_ATTEMPT && tmo_ticks != '0) |-> (att_cnt_q < {1'b0, tmo_ticks}));

  assert_off_follows_prs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_OFF && !prs) |-> !pwr_drive);

  assert_irq_hiz_unpowered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_good |-> !irq_low);

  assert_supply_loss_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_ON && !supply_good) |=> (state == PS_OFF));
endmodule

bind wake_power_ctrl wpc_checker #(
  .DAY_W(DAY_W), .HOUR_W(HOUR_W), .MIN_W(MIN_W), .SEC_W(SEC_W), .TMO_W(TMO_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cur_day(cur_day), .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
  .alm_day(alm_day), .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec),
  .supply_good(supply_good), .tmo_ticks(tmo_ticks), .int_en(int_en), .prs(prs),
  .flags(flags), .pdn_bit(pdn_bit), .irq_low(irq_low), .pwr_drive(pwr_drive),
  .state(state_q)
);

// File: tb/tb_wake_power_ctrl.sv
module tb_wake_power_ctrl;
  localparam int TMO = 10;

  logic clk, rst_n;
  logic [5:0] cur_day, alm_day, cur_min, alm_min, cur_sec, alm_sec;
  logic [4:0] cur_hour, alm_hour;
  logic kick_n, supply_good, prs, flags_rd, flags_wr, pdn_wr, pdn_wdata;
  logic [15:0] tmo_ticks;
  logic [1:0] int_en, flags_wdata, flags;
  logic pdn_bit, irq_low, pwr_drive;
  int checks = 0, errors = 0;
  bit done = 0;

  wake_power_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .cur_day(cur_day), .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
    .alm_day(alm_day), .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec),
    .kick_n(kick_n), .supply_good(supply_good), .tmo_ticks(tmo_ticks),
    .int_en(int_en), .prs(prs), .flags_rd(flags_rd), .flags_wr(flags_wr),
    .flags_wdata(flags_wdata), .pdn_wr(pdn_wr), .pdn_wdata(pdn_wdata),
    .flags(flags), .pdn_bit(pdn_bit), .irq_low(irq_low), .pwr_drive(pwr_drive)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic off_time();
    cur_day = 6'd1; cur_hour = 5'd0; cur_min = 6'd0; cur_sec = 6'd0;
  endtask

  task automatic kick_fall();
    kick_n = 0; step(3);
  endtask

  task automatic kick_rise();
    kick_n = 1; step(3);
  endtask

  task automatic t_reset();
    check("R8 reset flags", flags, 0);
    check("R8 reset pdn", pdn_bit, 1);
    check("R8 reset pwr", pwr_drive, 0);
    prs = 1; #1;
    check("R8 prs drives pwr when off", pwr_drive, 1);
    prs = 0; #1;
    check("R8 prs clear releases pwr", pwr_drive, 0);
  endtask

  task automatic t_kick_timeout();
    int_en = 2'b10;
    kick_n = 0; step(2);
    check("R2 kick flag not before third edge", flags[1], 0);
    step(1);
    check("R2 kick flag set", flags[1], 1);
    check("R5 attempt drives pwr", pwr_drive, 1);
    check("R10 irq hiz without supply", irq_low, 0);
    kick_n = 1;
    step(TMO - 1);
    check("R7 still attempting at last tick", pwr_drive, 1);
    step(1);
    check("R7 pwr released after timeout", pwr_drive, 0);
    check("R7 flag kept after timeout", flags[1], 1);
    step(2);
    check("R2 rising kick sets nothing", flags[0], 0);
    flags_rd = 1; step(1); flags_rd = 0;
    check("R4 read clears flags", flags, 0);
  endtask

  task automatic t_alarm_success();
    int_en = 2'b01;
    cur_day = alm_day; cur_hour = alm_hour; cur_min = alm_min; cur_sec = alm_sec + 6'd1;
    step(1);
    check("R1 seconds mismatch no flag", flags[0], 0);
    cur_sec = alm_sec; cur_hour = alm_hour + 5'd1;
    step(1);
    check("R1 hours mismatch no flag", flags[0], 0);
    cur_hour = alm_hour;
    step(1);
    check("R1 full match sets flag", flags[0], 1);
    check("R5 alarm attempt drives pwr", pwr_drive, 1);
    off_time();
    supply_good = 1; step(1);
    check("R5 pdn cleared on success", pdn_bit, 0);
    check("R5 pwr held on", pwr_drive, 1);
    check("R3 irq for enabled flag", irq_low, 1);
  endtask

  task automatic t_pdn_guard();
    pdn_wr = 1; pdn_wdata = 1; step(1); pdn_wr = 0;
    check("R6 pdn write ignored with flag", pdn_bit, 0);
    check("R6 pwr still on", pwr_drive, 1);
    flags_wr = 1; flags_wdata = 2'b10; step(1); flags_wr = 0;
    check("R4 write zero clears alarm flag", flags, 0);
    check("R3 irq released", irq_low, 0);
    pdn_wr = 1; pdn_wdata = 1; step(1); pdn_wr = 0;
    check("R6 pdn accepted", pdn_bit, 1);
    check("R6 pwr released", pwr_drive, 0);
  endtask

  task automatic t_rewake_powered();
    int_en = 2'b00;
    kick_fall();
    check("R3 masked flag still sets", flags[1], 1);
    check("R3 masked flag no irq", irq_low, 0);
    check("R9 masked event keeps pdn", pdn_bit, 1);
    flags_wr = 1; flags_wdata = 2'b11; step(1); flags_wr = 0;
    check("R4 write one keeps flag", flags[1], 1);
    flags_rd = 1; step(1); flags_rd = 0;
    kick_rise();
    int_en = 2'b10;
    kick_fall();
    check("R9 enabled event clears pdn", pdn_bit, 0);
    check("R9 enabled event drives pwr", pwr_drive, 1);
    check("R3 irq from kick", irq_low, 1);
    kick_n = 1;
  endtask

  task automatic t_supply_loss();
    supply_good = 0; #1;
    check("R10 irq hiz on supply loss", irq_low, 0);
    step(1);
    check("R11 off after supply loss", pwr_drive, 0);
    prs = 1; #1;
    check("R11 off state follows prs", pwr_drive, 1);
    prs = 0;
  endtask

  initial begin
    rst_n = 0; off_time();
    alm_day = 6'd5; alm_hour = 5'd7; alm_min = 6'd30; alm_sec = 6'd15;
    kick_n = 1; supply_good = 0; tmo_ticks = 16'(TMO); int_en = 0; prs = 0;
    flags_rd = 0; flags_wr = 0; flags_wdata = 0; pdn_wr = 0; pdn_wdata = 0;
    step(3); rst_n = 1; step(2);
    t_reset();
    t_kick_timeout();
    t_alarm_success();
    t_pdn_guard();
    t_rewake_powered();
    t_supply_loss();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule